// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-driven master for the two-wire PHY management bus. It divides its input clock down to make the management clock, serializes command frames onto the data line, and, for reads, lets go of the line at the turnaround and shifts in the sixteen bits the addressed PHY sends back. Software reaches it through one simple write strobe and a combinational read port over a word-aligned window of four registers. These are a configuration/status word at byte offset 0x30, a command word at 0x34, a data word at 0x38 and an extended-address word at 0x3C.

Each operation is started by the register write that supplies its last piece of information. Writing the data word sends a write frame. Writing the extended-address word in extended mode sends an address frame. Writing the command word with its read bit set sends a read frame. A mode bit picks between the legacy frame layout, where the 5-bit field in the command word is the register number, and the extended layout, where that field is the device number and registers are addressed by a separate address frame. Software polls the busy flag before and after each operation.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read zero, the management clock is low and the data line is released (output enable low).
- R2: While an operation runs, the management clock has a period of 2*(div+1) input clock cycles, where div is status bits 15:7. Between operations the clock stays low.
- R3: With status bit 6 clear, writing the data word (low 16 bits) sends a frame driven MSB first. The frame is 32 ones, start 01, opcode 01, the 5-bit port address (command bits 9:5), the 5-bit register number (command bits 4:0), turnaround 10, then the 16 data bits.
- R4: With status bit 6 clear, writing the command word with bit 15 set sends start 01, opcode 10, port and register fields taken from that write, then releases the line for the turnaround and all data bits. The 16 bits the PHY returns, MSB first, are stored in the data word and read error stays clear.
- R5: With status bit 6 set, writing the address word sends start 00, opcode 00, port, device, turnaround 10 and the 16-bit address. With bit 6 clear, the same write only stores the value and starts nothing.
- R6: With status bit 6 set, a data-word write sends start 00, opcode 01 and a read sends start 00, opcode 11. Both use the same field and turnaround rules as R3 and R4.
- R7: With status bit 5 set, the 32-bit run of ones is left out and the frame starts directly with the start pattern.
- R8: Busy (status bit 0) reads 1 from the cycle after the trigger write until the last falling clock edge of the frame. That is 2*N*(div+1) input cycles for an N-bit frame. The data line is released whenever busy is clear.
- R9: If the PHY does not pull the line low during the second turnaround bit of a read, read error (status bit 1) is set. With the line held high, the data word reads 0xFFFF. The flag reads 0 as soon as the next operation starts.
- R10: Writes to the command, data or address word that arrive while busy are ignored. They start no frame and leave the stored value unchanged.
- R11: Command bits 10, 11 and 14 are stored and read back but do not change any frame.
- R12: Only status bits 15:5 are writable. Writing all ones to the status word reads back 0x0000FFE0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value as seen on the pin |

## Verification
The hardest situation to create is a read in which the PHY answers with exact timing. The bench's PHY model must release the turnaround, pull the line low in the second turnaround bit, and present each data bit after a falling clock edge so that it is stable at the next rising edge. The model counts rising clock edges from the trigger and knows the frame length expected for the preamble setting, so it can drive the reply bit by bit. Randomized operations mix modes, opcodes, preamble suppression, divider values and reserved command bits, and some reads get no answer at all, so the error path and its clearing are exercised. A write aimed at the data word in the middle of a running frame shows that triggers are ignored while busy.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the management bus master.
// Assumes a 32-bit register port addressed by byte offset.
package mdio_pkg;
    localparam int REG_AW  = 6;
    localparam int REG_DW  = 32;
    localparam int FIELD_W = 5;
    localparam int WORD_W  = 16;
    localparam int BODY_W  = 2 + 2 + FIELD_W + FIELD_W + 2 + WORD_W;

    localparam logic [REG_AW-1:0] OFS_STAT = 6'h30;
    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h34;
    localparam logic [REG_AW-1:0] OFS_DATA = 6'h38;
    localparam logic [REG_AW-1:0] OFS_ADDR = 6'h3C;

    localparam int STAT_BUSY = 0;
    localparam int STAT_ERR  = 1;
    localparam int STAT_NPRE = 5;
    localparam int STAT_EXT  = 6;
    localparam int STAT_DIV  = 7;
    localparam int CTRL_RD   = 15;

    typedef enum logic [1:0] {
        FR_WRITE = 2'd0,
        FR_READ  = 2'd1,
        FR_ADDR  = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/mdio_regs.sv
// Module: register file and trigger decode.
// Holds the four software registers, decides which write launches which
// frame, and loads read data returned by the frame engine. All writes are
// dropped while an operation is in progress.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                busy,
    input  logic                rd_err,
    input  logic                rd_load,
    input  logic [WORD_W-1:0]   rd_value,
    output logic [DIV_W-1:0]    div,
    output logic                no_pre,
    output logic                ext_mode,
    output logic                launch,
    output frame_kind_e         launch_kind,
    output logic [FIELD_W-1:0]  launch_pa,
    output logic [FIELD_W-1:0]  launch_da,
    output logic [WORD_W-1:0]   launch_word
);
    localparam int PA_LSB = FIELD_W;

    logic [WORD_W-1:0] ctrl_q, data_q, addr_q;
    logic [DIV_W-1:0]  div_q;
    logic              no_pre_q, ext_q;
    logic hit_stat, hit_ctrl, hit_data, hit_addr;

    assign hit_stat = reg_wr && !busy && (reg_addr == OFS_STAT);
    assign hit_ctrl = reg_wr && !busy && (reg_addr == OFS_CTRL);
    assign hit_data = reg_wr && !busy && (reg_addr == OFS_DATA);
    assign hit_addr = reg_wr && !busy && (reg_addr == OFS_ADDR);

    // Purpose: store software writes and returned read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            data_q   <= '0;
            addr_q   <= '0;
            div_q    <= '0;
            no_pre_q <= 1'b0;
            ext_q    <= 1'b0;
        end else begin
            if (hit_stat) begin
                div_q    <= reg_wdata[STAT_DIV +: DIV_W];
                no_pre_q <= reg_wdata[STAT_NPRE];
                ext_q    <= reg_wdata[STAT_EXT];
            end
            if (hit_ctrl) ctrl_q <= reg_wdata[WORD_W-1:0];
            if (hit_data)     data_q <= reg_wdata[WORD_W-1:0];
            else if (rd_load) data_q <= rd_value;
            if (hit_addr) addr_q <= reg_wdata[WORD_W-1:0];
        end
    end

    // Purpose: pick the frame a write launches and its fields.
    always_comb begin
        launch      = 1'b0;
        launch_kind = FR_WRITE;
        launch_pa   = ctrl_q[PA_LSB +: FIELD_W];
        launch_da   = ctrl_q[FIELD_W-1:0];
        launch_word = reg_wdata[WORD_W-1:0];
        if (hit_ctrl && reg_wdata[CTRL_RD]) begin
            launch      = 1'b1;
            launch_kind = FR_READ;
            launch_pa   = reg_wdata[PA_LSB +: FIELD_W];
            launch_da   = reg_wdata[FIELD_W-1:0];
        end else if (hit_data) begin
            launch      = 1'b1;
            launch_kind = FR_WRITE;
        end else if (hit_addr && ext_q) begin
            launch      = 1'b1;
            launch_kind = FR_ADDR;
        end
    end

    // Purpose: combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT: begin
                reg_rdata[STAT_BUSY]          = busy;
                reg_rdata[STAT_ERR]           = rd_err;
                reg_rdata[STAT_NPRE]          = no_pre_q;
                reg_rdata[STAT_EXT]           = ext_q;
                reg_rdata[STAT_DIV +: DIV_W]  = div_q;
            end
            OFS_CTRL: reg_rdata[WORD_W-1:0] = ctrl_q;
            OFS_DATA: reg_rdata[WORD_W-1:0] = data_q;
            OFS_ADDR: reg_rdata[WORD_W-1:0] = addr_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign div      = div_q;
    assign no_pre   = no_pre_q;
    assign ext_mode = ext_q;
endmodule

// File: rtl/mdio_clkgen.sv
// Module: management clock divider.
// Runs only while 'run' is high; otherwise holds the clock low and the
// counter at zero. Each half period lasts div+1 input cycles. The rise and
// fall outputs are high in the cycle whose edge makes mdc toggle.
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap = run && (cnt_q == div);

    // Purpose: count half periods and toggle the clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign rise = wrap && !mdc_q;
    assign fall = wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: frame serializer and read deserializer.
// Loads a whole frame into a shift register at launch, changes the line
// after every falling clock edge and samples the returned bits at rising
// edges. Assumes launch is only asserted while idle.
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  frame_kind_e        kind,
    input  logic [FIELD_W-1:0] pa,
    input  logic [FIELD_W-1:0] da,
    input  logic [WORD_W-1:0]  word,
    input  logic               ext_mode,
    input  logic               no_pre,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               rd_err,
    output logic               rd_load,
    output logic [WORD_W-1:0]  rd_value
);
    localparam int FULL_W = PRE_LEN + BODY_W;
    localparam int CW     = $clog2(FULL_W + 1);
    localparam logic [CW-1:0] REM_TA1  = CW'(WORD_W + 2);
    localparam logic [CW-1:0] REM_TA2  = CW'(WORD_W + 1);
    localparam logic [CW-1:0] REM_REL  = CW'(WORD_W + 3);
    localparam logic [CW-1:0] REM_DATA = CW'(WORD_W);

    logic [FULL_W-1:0] sh_q;
    logic [CW-1:0]     rem_q;
    logic              busy_q, oe_q, is_rd_q, err_q;
    logic [WORD_W-1:0] cap_q;
    logic [BODY_W-1:0] body;

    // Purpose: assemble the frame after the preamble.
    always_comb begin
        logic [1:0] st, op, ta;
        logic [WORD_W-1:0] dw;
        st = ext_mode ? 2'b00 : 2'b01;
        ta = 2'b10;
        dw = word;
        case (kind)
            FR_READ: begin
                op = ext_mode ? 2'b11 : 2'b10;
                ta = 2'b11;
                dw = '1;
            end
            FR_ADDR: op = 2'b00;
            default: op = 2'b01;
        endcase
        body = {st, op, pa, da, ta, dw};
    end

    // Purpose: run the frame bit by bit on the divider ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            rem_q   <= '0;
            busy_q  <= 1'b0;
            oe_q    <= 1'b0;
            is_rd_q <= 1'b0;
            err_q   <= 1'b0;
            cap_q   <= '0;
        end else if (launch && !busy_q) begin
            busy_q  <= 1'b1;
            oe_q    <= 1'b1;
            err_q   <= 1'b0;
            is_rd_q <= (kind == FR_READ);
            if (no_pre) begin
                sh_q  <= {body, {PRE_LEN{1'b0}}};
                rem_q <= CW'(BODY_W);
            end else begin
                sh_q  <= {{PRE_LEN{1'b1}}, body};
                rem_q <= CW'(FULL_W);
            end
        end else if (busy_q) begin
            if (rise && is_rd_q) begin
                if (rem_q == REM_TA2 && mdio_i) err_q <= 1'b1;
                if (rem_q <= REM_DATA) cap_q <= {cap_q[WORD_W-2:0], mdio_i};
            end
            if (fall) begin
                sh_q  <= {sh_q[FULL_W-2:0], 1'b0};
                rem_q <= rem_q - 1'b1;
                if (is_rd_q && rem_q == REM_REL) oe_q <= 1'b0;
                if (rem_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign mdio_o   = sh_q[FULL_W-1];
    assign mdio_oe  = oe_q;
    assign rd_err   = err_q;
    assign rd_load  = busy_q && fall && is_rd_q && (rem_q == CW'(1));
    assign rd_value = cap_q;

    // REM_TA1 names the first turnaround slot for readability of the map.
    logic unused_ta1;
    assign unused_ta1 = ^REM_TA1;
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management bus master.
// Connects the register file, the clock divider and the frame engine.
// Assumes an external tri-state pad built from mdio_o / mdio_oe.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 9,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic               busy, rd_err, rd_load, launch;
    logic [WORD_W-1:0]  rd_value, launch_word;
    logic [DIV_W-1:0]   div;
    logic               no_pre, ext_mode, tick_rise, tick_fall;
    frame_kind_e        launch_kind;
    logic [FIELD_W-1:0] launch_pa, launch_da;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .rd_err(rd_err), .rd_load(rd_load), .rd_value(rd_value),
        .div(div), .no_pre(no_pre), .ext_mode(ext_mode),
        .launch(launch), .launch_kind(launch_kind),
        .launch_pa(launch_pa), .launch_da(launch_da),
        .launch_word(launch_word)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
        .mdc(mdc), .rise(tick_rise), .fall(tick_fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .kind(launch_kind),
        .pa(launch_pa), .da(launch_da), .word(launch_word),
        .ext_mode(ext_mode), .no_pre(no_pre),
        .rise(tick_rise), .fall(tick_fall), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_err(rd_err), .rd_load(rd_load), .rd_value(rd_value)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker bound into the master.
// Watches the register port, the bus pins and the internal busy/error flags.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              busy,
    input logic              rd_err
);
    assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_addr == OFS_DATA) |=> busy);

    assert_release_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |=> !mdio_oe);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_err);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy), .rd_err(rd_err)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam logic [5:0] A_STAT = 6'h30, A_CTRL = 6'h34, A_DATA = 6'h38, A_ADDR = 6'h3C;
    localparam int K_WR = 0, K_RD = 1, K_AD = 2;

    logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 1;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic mdc, mdio_o, mdio_oe;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, prev_rise = 0, last_per = 0;
    int n_rise = 0, frame_n = 64;
    logic [63:0] cap_bits = 0, cap_oe = 0;
    bit phy_ans = 0;
    logic [15:0] phy_val = 0;

    mdio_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: capture master bits at rising edges, answer after falling edges
    always @(posedge mdc) begin
        cap_bits = {cap_bits[62:0], mdio_oe ? mdio_o : 1'b0};
        cap_oe   = {cap_oe[62:0], mdio_oe};
        if (n_rise > 0) last_per = cyc - prev_rise;
        prev_rise = cyc;
        n_rise++;
    end
    always @(negedge mdc) begin
        int p;
        p = n_rise + 1;
        if (phy_ans && p >= frame_n - 16 && p <= frame_n)
            mdio_i = (p == frame_n - 16) ? 1'b0 : phy_val[frame_n - p];
        else
            mdio_i = 1'b1;
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = A_STAT;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] exp_body(bit ext, int k, logic [4:0] pa, logic [4:0] da,
                                             logic [15:0] w);
        logic [1:0] st, op, ta;
        st = ext ? 2'b00 : 2'b01;
        ta = 2'b10;
        if (k == K_RD) begin op = ext ? 2'b11 : 2'b10; ta = 2'b11; w = 16'hFFFF; end
        else if (k == K_AD) op = 2'b00;
        else op = 2'b01;
        return {st, op, pa, da, ta, w};
    endfunction

    // One full operation with frame, timing and result checks
    task automatic run_op(int k, bit ext, bit npre, int dv, logic [4:0] pa, logic [4:0] da,
                          logic [15:0] w, logic [15:0] xf, bit ans, logic [15:0] rv);
        logic [63:0] eb, eo, m;
        logic [31:0] v;
        int n, busy_cyc;
        n = npre ? 32 : 64;
        eb = npre ? {32'h0, exp_body(ext, k, pa, da, w)} : {32'hFFFFFFFF, exp_body(ext, k, pa, da, w)};
        m = (n == 64) ? 64'hFFFFFFFFFFFFFFFF : ((64'h1 << n) - 1);
        eo = (k == K_RD) ? (m & ~64'h3FFFF) : m;
        wr(A_STAT, (32'(dv) << 7) | (32'(ext) << 6) | (32'(npre) << 5));
        n_rise = 0; cap_bits = 0; cap_oe = 0; frame_n = n; phy_ans = ans; phy_val = rv;
        if (k == K_RD) wr(A_CTRL, {16'h0, 1'b1, xf[14:10], pa, da});
        else begin
            wr(A_CTRL, {16'h0, 1'b0, xf[14:10], pa, da});
            wr((k == K_AD) ? A_ADDR : A_DATA, {16'hA5A5, w});
        end
        busy_cyc = 0;
        #1;
        check(reg_rdata[1] == 1'b0, "R9 error clear at start", 64'(reg_rdata[1]), 0);
        while (reg_rdata[0] && busy_cyc < 5000) begin
            busy_cyc++;
            @(negedge clk); #1;
        end
        check(busy_cyc == 2 * n * (dv + 1), "R8 busy length", 64'(busy_cyc), 64'(2 * n * (dv + 1)));
        check(last_per == 2 * (dv + 1), "R2 mdc period", 64'(last_per), 64'(2 * (dv + 1)));
        check(n_rise == n, "R7 bit count", 64'(n_rise), 64'(n));
        check((cap_oe & m) == eo, k == K_RD ? "R4 release" : "R3 drive enable", cap_oe & m, eo);
        check((cap_bits & eo) == (eb & eo),
              ext ? "R6 extended frame" : (k == K_RD ? "R4 read frame" : "R3 write frame"),
              cap_bits & eo, eb & eo);
        if (k == K_RD) begin
            rd(A_STAT, v);
            check(v[1] == !ans, "R9 read error flag", 64'(v[1]), 64'(!ans));
            rd(A_DATA, v);
            check(v[15:0] == (ans ? rv : 16'hFFFF), "R4 read data", 64'(v[15:0]),
                  64'(ans ? rv : 16'hFFFF));
        end
        rd(A_CTRL, v);
        check(v[15:0] == {k == K_RD, xf[14:10], pa, da}, "R11 control readback",
              64'(v[15:0]), 64'({k == K_RD, xf[14:10], pa, da}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_STAT, v); check(v == 0, "R1 status reset", 64'(v), 0);
        rd(A_CTRL, v); check(v == 0, "R1 control reset", 64'(v), 0);
        rd(A_DATA, v); check(v == 0, "R1 data reset", 64'(v), 0);
        rd(A_ADDR, v); check(v == 0, "R1 address reset", 64'(v), 0);
        check(mdc == 0 && mdio_oe == 0, "R1 pins idle", {mdc, mdio_oe}, 0);
        // R12 writable status bits
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check(v == 32'h0000_FFE0, "R12 status mask", 64'(v), 64'h FFE0);
        // R5 address write in legacy mode starts nothing
        wr(A_STAT, 32'h0000_0280);
        wr(A_ADDR, 32'h0000_1234);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); check(v[0] == 0, "R5 no frame in legacy mode", 64'(v[0]), 0);
        rd(A_ADDR, v); check(v == 32'h1234, "R5 address stored", 64'(v), 64'h1234);
        // directed frames
        run_op(K_WR, 0, 0, 5, 5'h03, 5'h11, 16'hBEEF, 16'h0, 0, 0);      // R3
        run_op(K_RD, 0, 0, 5, 5'h1F, 5'h00, 16'h0, 16'h0, 1, 16'h8001);  // R4
        run_op(K_RD, 1, 1, 6, 5'h01, 5'h1E, 16'h0, 16'h0, 0, 0);         // R9 no answer, R7
        run_op(K_AD, 1, 0, 5, 5'h0A, 5'h05, 16'hC0DE, 16'h4C00, 0, 0);   // R5 R11
        run_op(K_WR, 1, 1, 5, 5'h15, 5'h07, 16'h0F0F, 16'h0, 0, 0);      // R6
        run_op(K_RD, 1, 0, 7, 5'h00, 5'h1F, 16'h0, 16'h0, 1, 16'h5AA5);  // R6 R9 clear
        // R10 writes while busy are ignored
        wr(A_STAT, 32'h0000_02A0);
        wr(A_CTRL, 32'h0000_0042);
        wr(A_DATA, 32'h0000_1111);
        repeat (20) @(negedge clk);
        wr(A_DATA, 32'h0000_2222);
        wr(A_CTRL, 32'h0000_8000);
        repeat (700) @(negedge clk);
        rd(A_STAT, v); check(v[0] == 0, "R10 no relaunch", 64'(v[0]), 0);
        rd(A_DATA, v); check(v == 32'h1111, "R10 data unchanged", 64'(v), 64'h1111);
        rd(A_CTRL, v); check(v == 32'h0042, "R10 control unchanged", 64'(v), 64'h42);
        // random operations
        for (int i = 0; i < 16; i++) begin
            int k, dv;
            bit ext, npre, ans;
            ext  = $urandom_range(0, 1);
            npre = $urandom_range(0, 1);
            k    = $urandom_range(0, 2);
            if (!ext && k == K_AD) k = K_WR;
            dv   = $urandom_range(5, 7);
            ans  = ($urandom_range(0, 3) != 0);
            run_op(k, ext, npre, dv, 5'($urandom), 5'($urandom), 16'($urandom),
                   16'($urandom) & 16'h4C00, ans, 16'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule